// File: doc/BRIEF.md
# Sleep and wakeup power controller

This block puts the CPU of a single-processor system to sleep and brings it back. Software programs a 32-bit control word over a simple register bus. The block then drives four things: a CPU clock gate, a CPU reset hold, a self-refresh request to the SDRAM controller and a maximum-clock-scale request to the clock generator.

There are two ways into sleep:
- The CPU raises a wait-for-interrupt request. The clock is gated, reset stays low, and the CPU resumes where it stopped.
- Software sets the legacy sleep bit. The clock is gated and the CPU is also held in reset for the whole sleep.

Either sleep ends when a wakeup source that software has enabled shows activity. The block restarts the clock and raises a sticky wake interrupt. When self refresh is enabled, entry and exit are handshaked with the memory controller. When clock scaling is enabled, the clock generator is asked for its top speed as soon as wake activity is seen.

Timers are frozen while the CPU sleeps, so no timer event is wired as a wake source. Only the external activity lines can end a sleep.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, the control word reads 0 and the status word reads 0. Outputs after reset: cpuClkEn=1, cpuRstHold=0, srReq=0, clkScaleReq=0, wakeIrq=0.
- R2: Address 0 holds the control word and address 1 holds the status word. Readback is combinational in the same cycle. Control word fields: bit 31 is legacy sleep, bit 30 is clock-scale enable, bit 21 is self-refresh enable, and bits 15:0 are the per-source wake enables. Bits 29:16 other than 21 read 0 and ignore writes.
- R3: While running, cpuWfi=1 at a clock edge gates the CPU clock (cpuClkEn=0) from that edge on. cpuRstHold stays 0 for the whole sleep.
- R4: Once control bit 31 reads 1, the next edge gates the CPU clock and asserts cpuRstHold. If both entry requests are present, this path wins over cpuWfi.
- R5: On waking from a legacy sleep, the clock is enabled while cpuRstHold is still 1. cpuRstHold drops one cycle later, and from then on control bit 31 reads 0.
- R6: Wake activity passes a two-flop synchronizer and is masked by control bits 15:0. When an enabled line rises before edge k, the sleep state is left at edge k+2. Activity on a line whose enable is 0 never ends sleep.
- R7: With bit 21=1 at entry, srReq rises in the same cycle the clock is gated, and sleep is not entered until srAck=1. On wake, srReq drops and the clock stays gated until srAck reads 0.
- R8: With bit 21=0 at entry, srReq stays 0 through the whole sleep and wake.
- R9: With bit 30=1, clkScaleReq is high for exactly the one cycle in which enabled wake activity is detected during sleep. With bit 30=0 it stays 0.
- R10: wakeIrq (also status bit 0) sets in the cycle after the clock restarts and stays set. Writing 1 to status bit 0 clears it; writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register address (0 control, 1 status) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational readback of the addressed register |
| cpuWfi | input | 1 | Wait-for-interrupt sleep request from the CPU |
| wakeAct | input | NUM_SRC | Asynchronous wakeup activity lines |
| srAck | input | 1 | Memory controller reports it is in self refresh |
| cpuClkEn | output | 1 | CPU clock enable (0 = gated) |
| cpuRstHold | output | 1 | Holds the CPU in reset |
| srReq | output | 1 | Level request for SDRAM self refresh |
| clkScaleReq | output | 1 | One-cycle request for maximum clock scale |
| wakeIrq | output | 1 | Sticky wake interrupt |

## Verification
The bench builds the block with its defaults: 16 wake sources, a 2-bit address and a 2-stage synchronizer. With these values the full 16-bit enable field and every reserved bit can be probed. The bench holds the self-refresh acknowledge back for several cycles on both entry and exit, which shows that the clock gate waits for the memory side. The short synchronizer keeps the wake latency at a fixed three edges, so the bench checks it cycle by cycle on both entry paths, with self refresh both on and off.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int LEGACY_BIT = 31;
  localparam int SCALE_BIT  = 30;
  localparam int SR_BIT     = 21;
  localparam int MAX_SRC    = 16;

  typedef enum logic [2:0] {
    RUN      = 3'd0,
    ENTER_SR = 3'd1,
    SLEEP    = 3'd2,
    EXIT_SR  = 3'd3,
    WAKE     = 3'd4
  } pwrState_t;

  typedef struct packed {
    logic setIrq;
    logic clrLegacy;
  } seqStrobe_t;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else if (s == 0) stage[s] <= din;
      else stage[s] <= stage[(s == 0) ? 0 : s - 1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwr_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] wakeAct,
  input  seqStrobe_t         strobe,
  output logic               legacyReq,
  output logic               srEn,
  output logic               scaleEn,
  output logic               wakeHit,
  output logic               wakeIrq
);
  localparam logic [ADDR_W-1:0] CTRL_A = '0;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(1);
  localparam logic [31:0] SRC_MASK = 32'((64'd1 << NUM_SRC) - 1);
  localparam logic [31:0] WR_MASK  = (32'd1 << LEGACY_BIT) | (32'd1 << SCALE_BIT)
                                   | (32'd1 << SR_BIT) | SRC_MASK;

  logic [31:0]        ctrlQ;
  logic               irqQ;
  logic [NUM_SRC-1:0] syncAct;
  logic               ctrlWr, statWr;

  assign ctrlWr = busWr && (busAddr == CTRL_A);
  assign statWr = busWr && (busAddr == STAT_A);

  pwr_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din(wakeAct), .dout(syncAct)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= busWdata & WR_MASK;
    end else if (strobe.clrLegacy) begin
      ctrlQ[LEGACY_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else if (strobe.setIrq) irqQ <= 1'b1;
    else if (statWr && busWdata[0]) irqQ <= 1'b0;
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == CTRL_A) busRdata = ctrlQ;
    else if (busAddr == STAT_A) busRdata = {31'b0, irqQ};
  end

  assign legacyReq = ctrlQ[LEGACY_BIT];
  assign srEn      = ctrlQ[SR_BIT];
  assign scaleEn   = ctrlQ[SCALE_BIT];
  assign wakeHit   = |(syncAct & ctrlQ[NUM_SRC-1:0]);
  assign wakeIrq   = irqQ;

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqQ && !(statWr && busWdata[0])) |=> irqQ);

  a_r5_legacy_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrLegacy && !ctrlWr) |=> !legacyReq);
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWfi,
  input  logic       legacyReq,
  input  logic       srEn,
  input  logic       scaleEn,
  input  logic       wakeHit,
  input  logic       srAck,
  output seqStrobe_t strobe,
  output logic       cpuClkEn,
  output logic       cpuRstHold,
  output logic       srReq,
  output logic       clkScaleReq
);
  pwrState_t state, stateNext;
  logic legacyPath, legacyPathNext;
  logic srUsed, srUsedNext;

  always_comb begin
    stateNext      = state;
    legacyPathNext = legacyPath;
    srUsedNext     = srUsed;
    unique case (state)
      RUN: if (legacyReq || cpuWfi) begin
        legacyPathNext = legacyReq;
        srUsedNext     = srEn;
        stateNext      = srEn ? ENTER_SR : SLEEP;
      end
      ENTER_SR: if (srAck) stateNext = SLEEP;
      SLEEP:    if (wakeHit) stateNext = srUsed ? EXIT_SR : WAKE;
      EXIT_SR:  if (!srAck) stateNext = WAKE;
      WAKE:     stateNext = RUN;
      default:  stateNext = RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= RUN;
      legacyPath <= 1'b0;
      srUsed     <= 1'b0;
    end else begin
      state      <= stateNext;
      legacyPath <= legacyPathNext;
      srUsed     <= srUsedNext;
    end
  end

  assign cpuClkEn         = (state == RUN) || (state == WAKE);
  assign cpuRstHold       = legacyPath && (state != RUN);
  assign srReq            = (state == ENTER_SR) || ((state == SLEEP) && srUsed);
  assign clkScaleReq      = (state == SLEEP) && wakeHit && scaleEn;
  assign strobe.setIrq    = (state == WAKE);
  assign strobe.clrLegacy = (state == WAKE) && legacyPath;

  a_r6_stay_asleep: assert property (@(posedge clk) disable iff (!rstN)
    (state == SLEEP && !wakeHit) |=> (state == SLEEP));

  a_r7_clk_after_sr_exit: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cpuClkEn) && srUsed) |-> !$past(srAck));

  a_r5_rst_after_clk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuRstHold) |-> $past(cpuClkEn));
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic               cpuWfi,
  input  logic [NUM_SRC-1:0] wakeAct,
  input  logic               srAck,
  output logic               cpuClkEn,
  output logic               cpuRstHold,
  output logic               srReq,
  output logic               clkScaleReq,
  output logic               wakeIrq
);
  seqStrobe_t strobe;
  logic legacyReq, srEn, scaleEn, wakeHit;

  initial begin
    assert (NUM_SRC >= 1 && NUM_SRC <= MAX_SRC);
  end

  pwr_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uRegs (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .wakeAct(wakeAct), .strobe(strobe), .legacyReq(legacyReq),
    .srEn(srEn), .scaleEn(scaleEn), .wakeHit(wakeHit), .wakeIrq(wakeIrq)
  );

  pwr_seq uSeq (
    .clk(clk), .rstN(rstN), .cpuWfi(cpuWfi), .legacyReq(legacyReq), .srEn(srEn),
    .scaleEn(scaleEn), .wakeHit(wakeHit), .srAck(srAck), .strobe(strobe),
    .cpuClkEn(cpuClkEn), .cpuRstHold(cpuRstHold), .srReq(srReq),
    .clkScaleReq(clkScaleReq)
  );
endmodule

// File: tb/tb_pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_sleep_ctrl;
  localparam int NUM_SRC = 16;
  localparam int ADDR_W  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic cpuWfi = 1'b0;
  logic [NUM_SRC-1:0] wakeAct = '0;
  logic srAck = 1'b0;
  logic cpuClkEn, cpuRstHold, srReq, clkScaleReq, wakeIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_sleep_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .cpuWfi(cpuWfi), .wakeAct(wakeAct), .srAck(srAck),
    .cpuClkEn(cpuClkEn), .cpuRstHold(cpuRstHold), .srReq(srReq),
    .clkScaleReq(clkScaleReq), .wakeIrq(wakeIrq)
  );

  // write data, expected readback of the control word (bit 31 kept 0)
  localparam logic [63:0] VEC [6] = '{
    {32'h0000_FFFF, 32'h0000_FFFF},
    {32'h7FFF_FFFF, 32'h4020_FFFF},
    {32'h3FDF_0000, 32'h0000_0000},
    {32'h0020_1234, 32'h0020_1234},
    {32'h4000_0000, 32'h4000_0000},
    {32'h0000_0000, 32'h0000_0000}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    tick();
    busWr = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a; #0.5; d = busRdata; busAddr = '0;
  endtask

  task automatic settle();
    wakeAct = '0; cpuWfi = 1'b0; srAck = 1'b0;
    repeat (3) tick();
    wr(2'd1, 32'h1);
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) tick();
    // R1 reset state
    rd(2'd0, r); check("R1", "ctrl", r, 32'h0);
    rd(2'd1, r); check("R1", "status", r, 32'h0);
    check("R1", "outs", {27'b0, cpuClkEn, cpuRstHold, srReq, clkScaleReq, wakeIrq},
          32'b10000);
    rstN = 1'b1;
    tick();

    // R2 register map via vector table
    foreach (VEC[i]) begin
      wr(2'd0, VEC[i][63:32]);
      rd(2'd0, r); check("R2", "ctrl readback", r, VEC[i][31:0]);
      check("R2", "no sleep", {31'b0, cpuClkEn}, 32'h1);
    end
    rd(2'd3, r); check("R2", "unused addr", r, 32'h0);

    // R3 R6 R9 R8: wfi path, no self refresh, scale on
    wr(2'd0, 32'h4000_0008);
    cpuWfi = 1'b1; tick();
    check("R3", "clk gated", {31'b0, cpuClkEn}, 32'h0);
    check("R3", "no reset", {31'b0, cpuRstHold}, 32'h0);
    check("R8", "no sr req", {31'b0, srReq}, 32'h0);
    cpuWfi = 1'b0;
    wakeAct[5] = 1'b1; repeat (5) tick();
    check("R6", "disabled src ignored", {31'b0, cpuClkEn}, 32'h0);
    check("R9", "no scale on disabled", {31'b0, clkScaleReq}, 32'h0);
    wakeAct[3] = 1'b1; tick(); tick();
    check("R6", "still asleep edge k+1", {31'b0, cpuClkEn}, 32'h0);
    check("R9", "scale pulse", {31'b0, clkScaleReq}, 32'h1);
    check("R10", "irq not yet", {31'b0, wakeIrq}, 32'h0);
    tick();
    check("R6", "awake edge k+2", {31'b0, cpuClkEn}, 32'h1);
    check("R9", "scale pulse ends", {31'b0, clkScaleReq}, 32'h0);
    check("R3", "no reset on wake", {31'b0, cpuRstHold}, 32'h0);
    check("R8", "no sr on wake", {31'b0, srReq}, 32'h0);
    tick();
    check("R10", "irq set", {31'b0, wakeIrq}, 32'h1);
    wakeAct = '0; repeat (3) tick();
    wr(2'd1, 32'h0);
    check("R10", "write 0 keeps", {31'b0, wakeIrq}, 32'h1);
    wr(2'd1, 32'h1);
    rd(2'd1, r); check("R10", "write 1 clears", r, 32'h0);

    // R4 R5 R9: legacy path, no self refresh, scale off, wfi also raised
    wr(2'd0, 32'h8000_0008);
    rd(2'd0, r); check("R4", "bit31 set", r, 32'h8000_0008);
    check("R4", "not yet gated", {30'b0, cpuClkEn, cpuRstHold}, 32'b10);
    cpuWfi = 1'b1; tick(); cpuWfi = 1'b0;
    check("R4", "gated and held", {30'b0, cpuClkEn, cpuRstHold}, 32'b01);
    wakeAct[3] = 1'b1; tick(); tick();
    check("R9", "scale off", {31'b0, clkScaleReq}, 32'h0);
    tick();
    check("R5", "clk on, still held", {30'b0, cpuClkEn, cpuRstHold}, 32'b11);
    tick();
    check("R5", "reset released", {30'b0, cpuClkEn, cpuRstHold}, 32'b10);
    rd(2'd0, r); check("R5", "bit31 cleared", r, 32'h0000_0008);
    settle();

    // R7: wfi path with self refresh
    wr(2'd0, 32'h0020_0008);
    cpuWfi = 1'b1; tick(); cpuWfi = 1'b0;
    check("R7", "sr req with gate", {30'b0, cpuClkEn, srReq}, 32'b01);
    repeat (3) tick();
    wakeAct[3] = 1'b1; repeat (4) tick();
    check("R7", "waits entry ack", {30'b0, cpuClkEn, srReq}, 32'b01);
    srAck = 1'b1; tick();
    check("R7", "sleep with sr", {30'b0, cpuClkEn, srReq}, 32'b01);
    tick();
    check("R7", "sr dropped on wake", {30'b0, cpuClkEn, srReq}, 32'b00);
    repeat (3) tick();
    check("R7", "clk waits exit ack", {31'b0, cpuClkEn}, 32'h0);
    srAck = 1'b0; tick();
    check("R7", "clk after exit ack", {30'b0, cpuClkEn, cpuRstHold}, 32'b10);
    tick();
    check("R10", "irq after sr wake", {31'b0, wakeIrq}, 32'h1);
    settle();

    // R4 R5 R7: legacy path with self refresh
    wr(2'd0, 32'h8020_0008);
    tick();
    check("R7", "legacy sr entry", {29'b0, cpuClkEn, cpuRstHold, srReq}, 32'b011);
    srAck = 1'b1; tick();
    wakeAct[3] = 1'b1; repeat (3) tick();
    check("R7", "legacy sr exit req", {29'b0, cpuClkEn, cpuRstHold, srReq}, 32'b010);
    srAck = 1'b0; tick();
    check("R5", "clk on held sr", {30'b0, cpuClkEn, cpuRstHold}, 32'b11);
    tick();
    check("R5", "released sr", {30'b0, cpuClkEn, cpuRstHold}, 32'b10);
    rd(2'd0, r); check("R5", "bit31 cleared sr", r, 32'h0020_0008);
    settle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule